// File: doc/BRIEF.md
# Imaging Front-End Control Register Port

This block holds the control settings of a three-channel imaging front end: one configuration word, one offset code per colour channel and one gain code per colour channel. All settings are presented as parallel outputs for the analog and converter logic around it. Software or a host controller loads them in one of two ways. The first is a serial port, which uses a data line and a bit clock. The second is a parallel port that borrows the converter's output bus for data and address. A single write strobe commits a write on either path.

Two mode pins choose the access path and decide whether the converter drives the shared bus. A mode with output-enable low and path-select high is prohibited, and no write takes effect in it. All pins are sampled in the system clock domain through a short synchronizer. Edges of the serial clock and the strobe are detected there.

Top module: `fe_cfg_port`

## Requirements
- R1: After reset, the configuration, all three offset codes and all three gain codes read zero.
- R2: The mode pins are read as {mode_oe_i, mode_ps_i}. With mode 00, the block drives bus_io with conv_data_i. In modes 01, 10 and 11, the block releases bus_io, so an external driver controls its value.
- R3: In mode 11, a rising strobe writes bus_io[7:0] to the register that bus_io[10:8] selects. Address 0 selects the configuration, which takes data bits [6:0]. Addresses 1, 2 and 3 select the red, green and blue offsets, which take all 8 bits. Addresses 4, 5 and 6 select the red, green and blue gains, which take data bits [4:0]. Each write changes at most one register.
- R4: A write to address 7 changes no register.
- R5: In mode 01, strobes and serial clock pulses change no register.
- R6: In modes 00 and 10, each rising serial-clock edge shifts in one bit. A frame is 3 address bits followed by 8 data bits, each MSB first. A rising strobe commits the frame with the same address map as R3.
- R7: A strobe that follows a number of serial bits other than 11 writes nothing. Every strobe restarts the bit count for the next frame.
- R8: In mode 10, a strobe does not take data or address from bus_io. In mode 11, serial clock pulses are not shifted in, so a later serial strobe without a fresh frame writes nothing.
- R9: Without a strobe, no register changes, whatever the serial clock, serial data and bus do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_oe_i | input | 1 | Output-enable mode pin (0 lets converter drive bus) |
| mode_ps_i | input | 1 | Path-select mode pin |
| wr_stb_i | input | 1 | Write strobe, commits on rising edge |
| ser_clk_i | input | 1 | Serial bit clock |
| ser_dat_i | input | 1 | Serial data |
| conv_data_i | input | CONV_W | Converter output word |
| bus_io | inout | CONV_W | Shared converter/register bus |
| cfg_o | output | 7 | Configuration word |
| off_r_o | output | 8 | Red offset code |
| off_g_o | output | 8 | Green offset code |
| off_b_o | output | 8 | Blue offset code |
| gain_r_o | output | 5 | Red gain code |
| gain_g_o | output | 5 | Green gain code |
| gain_b_o | output | 5 | Blue gain code |

## Verification
The outputs are plain register images, so a wrong bit counter or shift register shows up as a whole write landing in the wrong place or missing. A fault in address decode shows up as a setting on a neighbouring channel. These effects appear on the outputs a few clocks after the strobe edge, once the synchronizer latency has passed. The bench sweeps every address on both paths with several data patterns. It also sends frames that are too short and too long, and it uses the prohibited and cross-path modes. After each step it compares all seven outputs with an arithmetic model.

// File: rtl/fe_cfg_pkg.sv
package fe_cfg_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int CFG_W  = 7;
    localparam int GAIN_W = 5;
    localparam int NUM_CH = 3;
    localparam int FRAME_W = ADDR_W + DATA_W;

    localparam logic [ADDR_W-1:0] ADR_CFG      = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_OFF_BASE = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_GN_BASE  = 3'd4;

    typedef enum logic [1:0] {
        MODE_SER_CONV = 2'b00,
        MODE_BAD      = 2'b01,
        MODE_SER      = 2'b10,
        MODE_PAR      = 2'b11
    } mode_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/fe_cfg_edge.sv
module fe_cfg_edge #(
    parameter int N    = 3,
    parameter int SYNC = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] in_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [SYNC-1:0][N-1:0] sync;
        logic [N-1:0]           prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = in_i;
        for (int i = 1; i < SYNC; i++) begin
            st_d.sync[i] = st_q.sync[i-1];
        end
        st_d.prev = st_q.sync[SYNC-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign level_o = st_q.sync[SYNC-1];
    assign rise_o  = st_q.sync[SYNC-1] & ~st_q.prev;
endmodule

// File: rtl/fe_cfg_serial.sv
module fe_cfg_serial #(
    parameter int FRAME_W = 11,
    localparam int CNT_W  = $clog2(FRAME_W + 2)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               shift_i,
    input  logic               bit_i,
    input  logic               clear_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic               full_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (shift_i) begin
            st_d.sh = {st_q.sh[FRAME_W-2:0], bit_i};
            if (st_q.cnt != CNT_OVER) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign frame_o = st_q.sh;
    assign full_o  = (st_q.cnt == CNT_FULL);
endmodule

// File: rtl/fe_cfg_regbank.sv
module fe_cfg_regbank
    import fe_cfg_pkg::*;
(
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  wr_req_t                       wr_i,
    output logic [CFG_W-1:0]              cfg_o,
    output logic [NUM_CH-1:0][DATA_W-1:0] off_o,
    output logic [NUM_CH-1:0][GAIN_W-1:0] gain_o
);
    typedef struct packed {
        logic [CFG_W-1:0]              cfg;
        logic [NUM_CH-1:0][DATA_W-1:0] off;
        logic [NUM_CH-1:0][GAIN_W-1:0] gain;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_i.valid) begin
            if (wr_i.addr == ADR_CFG) bank_d.cfg = wr_i.data[CFG_W-1:0];
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (wr_i.addr == ADR_OFF_BASE + ADDR_W'(ch))
                    bank_d.off[ch] = wr_i.data;
                if (wr_i.addr == ADR_GN_BASE + ADDR_W'(ch))
                    bank_d.gain[ch] = wr_i.data[GAIN_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bank_q <= '0;
        else         bank_q <= bank_d;
    end

    assign cfg_o  = bank_q.cfg;
    assign off_o  = bank_q.off;
    assign gain_o = bank_q.gain;
endmodule

// File: rtl/fe_cfg_port.sv
module fe_cfg_port
    import fe_cfg_pkg::*;
#(
    parameter int CONV_W = 12,
    parameter int SYNC   = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mode_oe_i,
    input  logic              mode_ps_i,
    input  logic              wr_stb_i,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic [CONV_W-1:0] conv_data_i,
    inout  wire  [CONV_W-1:0] bus_io,
    output logic [6:0]        cfg_o,
    output logic [7:0]        off_r_o,
    output logic [7:0]        off_g_o,
    output logic [7:0]        off_b_o,
    output logic [4:0]        gain_r_o,
    output logic [4:0]        gain_g_o,
    output logic [4:0]        gain_b_o
);
    localparam int IDX_STB = 0;
    localparam int IDX_SCK = 1;
    localparam int IDX_SDA = 2;

    logic [2:0] pin_lvl, pin_rise;
    logic [FRAME_W-1:0] frame;
    logic frame_full;
    mode_e mode;
    logic ser_mode, par_mode, shift_en;

    typedef struct packed {
        wr_req_t wr;
    } st_t;

    st_t st_d, st_q;

    fe_cfg_edge #(.N(3), .SYNC(SYNC)) edge_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .in_i    ({ser_dat_i, ser_clk_i, wr_stb_i}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise)
    );

    assign mode     = mode_e'({mode_oe_i, mode_ps_i});
    assign ser_mode = (mode == MODE_SER_CONV) || (mode == MODE_SER);
    assign par_mode = (mode == MODE_PAR);
    assign shift_en = pin_rise[IDX_SCK] && ser_mode;

    fe_cfg_serial #(.FRAME_W(FRAME_W)) ser_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .shift_i (shift_en),
        .bit_i   (pin_lvl[IDX_SDA]),
        .clear_i (pin_rise[IDX_STB]),
        .frame_o (frame),
        .full_o  (frame_full)
    );

    always_comb begin
        st_d = st_q;
        st_d.wr.valid = 1'b0;
        if (pin_rise[IDX_STB]) begin
            if (par_mode) begin
                st_d.wr.valid = 1'b1;
                st_d.wr.addr  = bus_io[DATA_W+ADDR_W-1:DATA_W];
                st_d.wr.data  = bus_io[DATA_W-1:0];
            end else if (ser_mode && frame_full) begin
                st_d.wr.valid = 1'b1;
                st_d.wr.addr  = frame[FRAME_W-1:DATA_W];
                st_d.wr.data  = frame[DATA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bus_io = (mode == MODE_SER_CONV) ? conv_data_i : {CONV_W{1'bz}};

    logic [NUM_CH-1:0][DATA_W-1:0] off_all;
    logic [NUM_CH-1:0][GAIN_W-1:0] gain_all;

    fe_cfg_regbank bank_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (st_q.wr),
        .cfg_o  (cfg_o),
        .off_o  (off_all),
        .gain_o (gain_all)
    );

    assign off_r_o  = off_all[0];
    assign off_g_o  = off_all[1];
    assign off_b_o  = off_all[2];
    assign gain_r_o = gain_all[0];
    assign gain_g_o = gain_all[1];
    assign gain_b_o = gain_all[2];

    logic             wr_vld;
    logic [ADDR_W-1:0] wr_adr;
    assign wr_vld = st_q.wr.valid;
    assign wr_adr = st_q.wr.addr;
endmodule

// File: rtl/fe_cfg_port_chk.sv
module fe_cfg_port_chk #(
    parameter int CONV_W = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              mode_oe_i,
    input logic              mode_ps_i,
    input logic [CONV_W-1:0] conv_data_i,
    input logic [CONV_W-1:0] bus_io,
    input logic              wr_vld,
    input logic [2:0]        wr_adr,
    input logic [6:0]        cfg_o,
    input logic [7:0]        off_r_o,
    input logic [7:0]        off_g_o,
    input logic [7:0]        off_b_o,
    input logic [4:0]        gain_r_o,
    input logic [4:0]        gain_g_o,
    input logic [4:0]        gain_b_o
);
    logic [45:0] regs_all;
    assign regs_all = {cfg_o, off_r_o, off_g_o, off_b_o, gain_r_o, gain_g_o, gain_b_o};

    AST_BUS_DRIVES_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_oe_i && !mode_ps_i) |-> (bus_io == conv_data_i)); // R2

    AST_RESERVED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_vld && wr_adr == 3'b111) |=> $stable(regs_all)); // R4

    AST_PROHIB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!mode_oe_i && mode_ps_i && $past(!mode_oe_i && mode_ps_i)) |=> $stable(regs_all)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_vld |=> $stable(regs_all)); // R9

    AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_vld |=> ($countones({!$stable(cfg_o), !$stable(off_r_o), !$stable(off_g_o),
                                !$stable(off_b_o), !$stable(gain_r_o), !$stable(gain_g_o),
                                !$stable(gain_b_o)}) <= 1)); // R3
endmodule

bind fe_cfg_port fe_cfg_port_chk #(.CONV_W(CONV_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_oe_i   (mode_oe_i),
    .mode_ps_i   (mode_ps_i),
    .conv_data_i (conv_data_i),
    .bus_io      (bus_io),
    .wr_vld      (wr_vld),
    .wr_adr      (wr_adr),
    .cfg_o       (cfg_o),
    .off_r_o     (off_r_o),
    .off_g_o     (off_g_o),
    .off_b_o     (off_b_o),
    .gain_r_o    (gain_r_o),
    .gain_g_o    (gain_g_o),
    .gain_b_o    (gain_b_o)
);

// File: tb/fe_cfg_port_tb.sv
module fe_cfg_port_tb_top;
    localparam int CW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_oe = 1'b1, m_ps = 1'b1;
    logic stb = 1'b0, sck = 1'b0, sda = 1'b0;
    logic [CW-1:0] conv = '0;
    logic [CW-1:0] tb_bus = '0;
    logic tb_bus_en = 1'b0;
    wire  [CW-1:0] bus_w;
    logic [6:0] cfg;
    logic [7:0] off_r, off_g, off_b;
    logic [4:0] gn_r, gn_g, gn_b;

    int checks = 0;
    int fails = 0;

    logic [6:0] e_cfg = '0;
    logic [7:0] e_off [3];
    logic [4:0] e_gn [3];

    assign bus_w = tb_bus_en ? tb_bus : {CW{1'bz}};

    always #2.5 clk = ~clk;

    fe_cfg_port #(.CONV_W(CW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .mode_oe_i(m_oe), .mode_ps_i(m_ps),
        .wr_stb_i(stb), .ser_clk_i(sck), .ser_dat_i(sda), .conv_data_i(conv),
        .bus_io(bus_w), .cfg_o(cfg), .off_r_o(off_r), .off_g_o(off_g), .off_b_o(off_b),
        .gain_r_o(gn_r), .gain_g_o(gn_g), .gain_b_o(gn_b)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_write(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: e_cfg = d[6:0];
            3'd1: e_off[0] = d;
            3'd2: e_off[1] = d;
            3'd3: e_off[2] = d;
            3'd4: e_gn[0] = d[4:0];
            3'd5: e_gn[1] = d[4:0];
            3'd6: e_gn[2] = d[4:0];
            default: ;
        endcase
    endtask

    task automatic chk_regs(input string tag);
        logic [45:0] got, exp;
        got = {cfg, off_r, off_g, off_b, gn_r, gn_g, gn_b};
        exp = {e_cfg, e_off[0], e_off[1], e_off[2], e_gn[0], e_gn[1], e_gn[2]};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s regs got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic set_mode(input logic oe, input logic ps);
        m_oe = oe;
        m_ps = ps;
        tb_bus_en = !(oe == 1'b0 && ps == 1'b0);
        wait_clk(2);
    endtask

    task automatic strobe();
        stb = 1'b1;
        wait_clk(6);
        stb = 1'b0;
        wait_clk(6);
    endtask

    task automatic par_write(input logic [2:0] a, input logic [7:0] d);
        tb_bus = {1'b0, a, d};
        wait_clk(2);
        strobe();
    endtask

    task automatic ser_bits(input logic [10:0] frame, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            sda = (i < 11) ? frame[10 - i] : 1'b1;
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
            wait_clk(2);
        end
    endtask

    task automatic ser_write(input logic [2:0] a, input logic [7:0] d, input int nbits);
        ser_bits({a, d}, nbits);
        strobe();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 3; c++) begin
            e_off[c] = '0;
            e_gn[c] = '0;
        end
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        chk_regs("R1 reset");

        // R2: shared bus owner per mode
        set_mode(1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            conv = CW'(k * 1237 + 291);
            wait_clk(1);
            checks++;
            if (bus_w !== conv) begin
                fails++;
                $display("FAIL R2 bus got=%h exp=%h", bus_w, conv);
            end
        end
        for (int m = 1; m < 4; m++) begin
            set_mode(m[1], m[0]);
            tb_bus = CW'(12'hA5C ^ m);
            wait_clk(1);
            checks++;
            if (bus_w !== tb_bus) begin
                fails++;
                $display("FAIL R2 released bus got=%h exp=%h", bus_w, tb_bus);
            end
        end

        // R3/R4: parallel sweep
        set_mode(1'b1, 1'b1);
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 8; a++) begin
                logic [7:0] d;
                d = 8'(a * 37 + p * 91 + 5);
                if (p == 3) d = 8'hFF;
                par_write(3'(a), d);
                model_write(3'(a), d);
                chk_regs(a == 7 ? "R4 reserved parallel" : "R3 parallel write");
            end
        end

        // R6: serial sweep in both serial modes
        for (int p = 0; p < 3; p++) begin
            set_mode(p[0], 1'b0);
            for (int a = 0; a < 8; a++) begin
                logic [7:0] d;
                d = 8'(a * 53 + p * 29 + 200);
                ser_write(3'(a), d, 11);
                model_write(3'(a), d);
                chk_regs(a == 7 ? "R4 reserved serial" : "R6 serial write");
            end
        end

        // R7: wrong frame lengths, then count restart
        set_mode(1'b1, 1'b0);
        ser_write(3'd1, 8'h3C, 10);
        chk_regs("R7 short frame");
        ser_write(3'd2, 8'hC3, 12);
        chk_regs("R7 long frame");
        ser_bits(11'h5A5, 5);
        strobe();
        ser_write(3'd3, 8'h77, 11);
        model_write(3'd3, 8'h77);
        chk_regs("R7 restart after strobe");

        // R5: prohibited mode ignores both paths
        set_mode(1'b0, 1'b1);
        tb_bus = {1'b0, 3'd1, 8'h99};
        ser_bits({3'd4, 8'h1F}, 11);
        strobe();
        chk_regs("R5 prohibited");

        // R8: serial mode ignores bus; parallel mode ignores sclk
        set_mode(1'b1, 1'b0);
        tb_bus = {1'b0, 3'd5, 8'h0A};
        strobe();
        chk_regs("R8 bus ignored in serial mode");
        set_mode(1'b1, 1'b1);
        tb_bus = {1'b0, 3'd7, 8'h00};
        ser_bits({3'd6, 8'h15}, 11);
        set_mode(1'b1, 1'b0);
        strobe();
        chk_regs("R8 sclk ignored in parallel mode");

        // R9: activity without strobe
        ser_bits({3'd2, 8'hEE}, 11);
        tb_bus = {1'b0, 3'd0, 8'h55};
        wait_clk(10);
        chk_regs("R9 no strobe");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule